// File: doc/BRIEF.md
# Generational Pool Replacement Controller

This block chooses which entry of a fully associative cache is evicted on a miss. Block slots are spread over a handful of priority pools plus one fresh pool for newly filled blocks. Each pool is a first-in first-out queue of slot numbers. All pools share one array of next-slot links, and each pool has its own head, tail and count registers. Each slot also has one reference bit.

A hit on a slot only sets that slot's reference bit. A miss starts a fixed-length sequence, and the controller reports busy while it runs. In that sequence the head of every pool that held blocks at the start is taken in turn: first the fresh pool, then the priority pools from lowest to highest. A referenced head climbs one pool and an unreferenced head drops one pool, and its bit is cleared either way. After that, the head of the lowest non-empty priority pool becomes the victim. Its slot goes to the tail of the fresh pool, ready for the incoming block. Tag matching, hashing and data storage sit outside this block.

Top module: `generational_pool_repl`

## Requirements
- R1: Reset clears every reference bit, empties every pool except pool 0, and queues all slots in pool 0 in ascending order (slot 0 at the head). Busy and the victim strobe are both low after reset.
- R2: A miss request accepted while idle holds busy high for exactly N_POOLS+2 cycles. Busy first reads high on the cycle after the accepting edge. The victim strobe pulses for one cycle, on the cycle in which busy reads low again.
- R3: A miss request that arrives while busy is high is ignored. It starts no extra sequence and produces no extra victim.
- R4: A hit seen while idle changes only the hit slot's reference bit. No pool order changes until the next miss.
- R5: The heads are processed in a fixed order: the fresh pool first, then priority pools 0 up to N_POOLS-1, one pool per cycle. Only pools that were non-empty when the miss was accepted are processed. A processed head is removed from the front of its pool, and its reference bit is cleared.
- R6: A head in a middle priority pool moves to the tail of the pool one above if its bit was set, or one below if its bit was clear. A set head in the top pool moves to the tail of the top pool. A clear head in pool 0 stays at the head of pool 0.
- R7: A head taken from the fresh pool joins the tail of pool 1 if its bit was set, and the tail of pool 0 if its bit was clear.
- R8: In the last busy cycle the victim is the head of the lowest non-empty priority pool. If every priority pool is empty, the victim is the head of the fresh pool. The victim slot moves to the tail of the fresh pool with its bit cleared, and its number appears on victim_idx while the strobe is high.
- R9: Hits arriving while busy still set reference bits. A hit on a slot whose bit is cleared on the same edge wins, and the bit ends set.
- R10: Every slot is always in exactly one pool, so the pool counts always add up to N_BLOCKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A cache hit occurred this cycle |
| hit_idx | input | $clog2(N_BLOCKS) | Slot that was hit |
| miss_req | input | 1 | A cache miss needs a victim |
| busy | output | 1 | Miss sequence in progress |
| victim_valid | output | 1 | One-cycle strobe: victim_idx is valid |
| victim_idx | output | $clog2(N_BLOCKS) | Slot chosen for eviction |

## Verification
With no hits at all, the victims must come out in plain rotation. This shows that unreferenced blocks fall back to pool 0 and leave through it. Hits on a few chosen slots, followed by misses, show the climb into higher pools, the rotation in the top pool and the fresh-pool exits. Each of these moves changes which slot is evicted later. Hits timed inside the busy window, including hits on the head being cleared, separate a design where the hit wins from one where the clear wins. Long random mixes of hits, misses and misses held high while busy test the pool linkage against a queue model over many evictions.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROC = 2'd1,
        ST_VICT = 2'd2
    } gpr_state_e;

    // Destination pool for a processed head. Pool n_pools is the fresh pool.
    function automatic int unsigned gpr_next_pool(input int unsigned pool,
                                                  input logic        refd,
                                                  input int unsigned n_pools);
        if (pool == n_pools)
            return refd ? 1 : 0;
        if (refd)
            return (pool == n_pools - 1) ? pool : pool + 1;
        return (pool == 0) ? 0 : pool - 1;
    endfunction

endpackage

// File: rtl/gpr_refbits.sv
module gpr_refbits #(
    parameter int N_BLOCKS = 16,
    localparam int IW = $clog2(N_BLOCKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_en,
    input  logic [IW-1:0]       clr_idx,
    input  logic                hit_en,
    input  logic [IW-1:0]       hit_idx,
    output logic [N_BLOCKS-1:0] ref_vec
);
    for (genvar i = 0; i < N_BLOCKS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                ref_vec[i] <= 1'b0;
            else if (hit_en && hit_idx == IW'(i))
                ref_vec[i] <= 1'b1;          // hit wins over a same-edge clear
            else if (clr_en && clr_idx == IW'(i))
                ref_vec[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/gpr_pool_lists.sv
module gpr_pool_lists #(
    parameter int N_BLOCKS = 16,
    parameter int N_LISTS  = 5,
    localparam int IW = $clog2(N_BLOCKS),
    localparam int CW = $clog2(N_BLOCKS + 1),
    localparam int LW = $clog2(N_LISTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mv_en,
    input  logic [LW-1:0]           mv_src,
    input  logic [LW-1:0]           mv_dst,
    output logic [N_LISTS*IW-1:0]   head_flat,
    output logic [N_LISTS*CW-1:0]   cnt_flat
);
    logic [IW-1:0] nxt  [N_BLOCKS];
    logic [IW-1:0] head [N_LISTS];
    logic [IW-1:0] tail [N_LISTS];
    logic [CW-1:0] cnt  [N_LISTS];
    logic [IW-1:0] mv_h;

    assign mv_h = head[mv_src];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_BLOCKS; i++)
                nxt[i] <= IW'((i + 1) % N_BLOCKS);
            for (int l = 0; l < N_LISTS; l++) begin
                head[l] <= '0;
                tail[l] <= (l == 0) ? IW'(N_BLOCKS - 1) : '0;
                cnt[l]  <= (l == 0) ? CW'(N_BLOCKS) : '0;
            end
        end else if (mv_en) begin
            if (mv_src == mv_dst) begin
                if (cnt[mv_src] > CW'(1)) begin
                    head[mv_src]      <= nxt[mv_h];
                    nxt[tail[mv_src]] <= mv_h;
                    tail[mv_src]      <= mv_h;
                end
            end else begin
                head[mv_src] <= nxt[mv_h];
                cnt[mv_src]  <= cnt[mv_src] - CW'(1);
                if (cnt[mv_dst] == '0)
                    head[mv_dst] <= mv_h;
                else
                    nxt[tail[mv_dst]] <= mv_h;
                tail[mv_dst] <= mv_h;
                cnt[mv_dst]  <= cnt[mv_dst] + CW'(1);
            end
        end
    end

    for (genvar l = 0; l < N_LISTS; l++) begin : g_flat
        assign head_flat[l*IW +: IW] = head[l];
        assign cnt_flat[l*CW +: CW]  = cnt[l];
    end
endmodule

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
    import gpr_pkg::*;
#(
    parameter int N_BLOCKS = 16,
    parameter int N_POOLS  = 4,
    localparam int N_LISTS = N_POOLS + 1,
    localparam int IW = $clog2(N_BLOCKS),
    localparam int CW = $clog2(N_BLOCKS + 1),
    localparam int LW = $clog2(N_LISTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   miss_req,
    input  logic [N_LISTS*IW-1:0]  head_flat,
    input  logic [N_LISTS*CW-1:0]  cnt_flat,
    input  logic [N_BLOCKS-1:0]    ref_vec,
    output logic                   mv_en,
    output logic [LW-1:0]          mv_src,
    output logic [LW-1:0]          mv_dst,
    output logic                   clr_en,
    output logic [IW-1:0]          clr_idx,
    output logic                   busy,
    output logic                   victim_valid,
    output logic [IW-1:0]          victim_idx
);
    localparam logic [LW-1:0] FRESH = LW'(N_POOLS);

    gpr_state_e         st;
    logic [LW-1:0]      step;
    logic [N_LISTS-1:0] mask;
    logic [N_LISTS-1:0] nonempty;
    logic [IW-1:0]      heads [N_LISTS];
    logic [LW-1:0]      cur_pool;
    logic [IW-1:0]      cur_head;
    logic               cur_ref;
    logic [LW-1:0]      cur_dest;
    logic [LW-1:0]      vict_pool;

    for (genvar l = 0; l < N_LISTS; l++) begin : g_unpack
        assign heads[l]    = head_flat[l*IW +: IW];
        assign nonempty[l] = (cnt_flat[l*CW +: CW] != '0);
    end

    assign cur_pool = (step == '0) ? FRESH : step - LW'(1);
    assign cur_head = heads[cur_pool];
    assign cur_ref  = ref_vec[cur_head];
    assign cur_dest = LW'(gpr_next_pool(int'(cur_pool), cur_ref, N_POOLS));

    always_comb begin
        vict_pool = FRESH;
        for (int p = N_POOLS - 1; p >= 0; p--)
            if (nonempty[p]) vict_pool = LW'(p);
    end

    always_comb begin
        mv_en   = 1'b0;
        mv_src  = cur_pool;
        mv_dst  = cur_dest;
        clr_en  = 1'b0;
        clr_idx = cur_head;
        if (st == ST_PROC) begin
            clr_en = mask[cur_pool];
            mv_en  = mask[cur_pool] && !(cur_pool == '0 && !cur_ref);
        end else if (st == ST_VICT) begin
            mv_en   = 1'b1;
            mv_src  = vict_pool;
            mv_dst  = FRESH;
            clr_en  = 1'b1;
            clr_idx = heads[vict_pool];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            step         <= '0;
            mask         <= '0;
            victim_valid <= 1'b0;
            victim_idx   <= '0;
        end else begin
            victim_valid <= 1'b0;
            case (st)
                ST_IDLE: if (miss_req) begin
                    st   <= ST_PROC;
                    step <= '0;
                    mask <= nonempty;
                end
                ST_PROC: begin
                    step <= step + LW'(1);
                    if (step == LW'(N_POOLS)) st <= ST_VICT;
                end
                ST_VICT: begin
                    st           <= ST_IDLE;
                    victim_valid <= 1'b1;
                    victim_idx   <= heads[vict_pool];
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/generational_pool_repl.sv
module generational_pool_repl #(
    parameter int N_BLOCKS = 16,
    parameter int N_POOLS  = 4,
    localparam int N_LISTS = N_POOLS + 1,
    localparam int IW = $clog2(N_BLOCKS),
    localparam int CW = $clog2(N_BLOCKS + 1),
    localparam int LW = $clog2(N_LISTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_valid,
    input  logic [IW-1:0] hit_idx,
    input  logic          miss_req,
    output logic          busy,
    output logic          victim_valid,
    output logic [IW-1:0] victim_idx
);
    logic [N_LISTS*IW-1:0] head_flat;
    logic [N_LISTS*CW-1:0] pool_cnt_flat;
    logic [N_BLOCKS-1:0]   ref_vec;
    logic                  mv_en, clr_en;
    logic [LW-1:0]         mv_src, mv_dst;
    logic [IW-1:0]         clr_idx;

    gpr_refbits #(.N_BLOCKS(N_BLOCKS)) u_ref (
        .clk(clk), .rst(rst),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .hit_en(hit_valid), .hit_idx(hit_idx),
        .ref_vec(ref_vec)
    );

    gpr_pool_lists #(.N_BLOCKS(N_BLOCKS), .N_LISTS(N_LISTS)) u_lists (
        .clk(clk), .rst(rst),
        .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
        .head_flat(head_flat), .cnt_flat(pool_cnt_flat)
    );

    gpr_ctrl #(.N_BLOCKS(N_BLOCKS), .N_POOLS(N_POOLS)) u_ctrl (
        .clk(clk), .rst(rst), .miss_req(miss_req),
        .head_flat(head_flat), .cnt_flat(pool_cnt_flat), .ref_vec(ref_vec),
        .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .busy(busy), .victim_valid(victim_valid), .victim_idx(victim_idx)
    );
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker #(
    parameter int N_BLOCKS = 16,
    parameter int N_POOLS  = 4,
    localparam int N_LISTS = N_POOLS + 1,
    localparam int IW = $clog2(N_BLOCKS),
    localparam int CW = $clog2(N_BLOCKS + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  miss_req,
    input logic                  busy,
    input logic                  victim_valid,
    input logic [IW-1:0]         victim_idx,
    input logic [N_LISTS*CW-1:0] pool_cnt_flat
);
    int unsigned total;
    int unsigned busy_len;

    always_comb begin
        total = 0;
        for (int l = 0; l < N_LISTS; l++)
            total += int'(pool_cnt_flat[l*CW +: CW]);
    end

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R10
    count_conserved_chk: assert property (@(posedge clk) disable iff (rst)
        total == N_BLOCKS);

    // R2
    miss_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_req) |=> busy);

    // R2
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_len == N_POOLS + 1) |=> !busy);

    // R2
    busy_min_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_len < N_POOLS + 1) |=> busy);

    // R2
    victim_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |=> !victim_valid);

    // R2
    victim_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> victim_valid);

    // R8
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> (int'(victim_idx) < N_BLOCKS));
endmodule

bind generational_pool_repl gpr_checker #(.N_BLOCKS(N_BLOCKS), .N_POOLS(N_POOLS)) u_gpr_chk (
    .clk(clk), .rst(rst), .miss_req(miss_req), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx),
    .pool_cnt_flat(pool_cnt_flat)
);

// File: tb/test_generational_pool_repl.sv
module test_generational_pool_repl;
    localparam int NB = 16;
    localparam int NP = 4;
    localparam int NL = NP + 1;
    localparam int FR = NP;
    localparam int IW = $clog2(NB);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_valid = 1'b0;
    logic [IW-1:0] hit_idx = '0;
    logic miss_req = 1'b0;
    logic busy, victim_valid;
    logic [IW-1:0] victim_idx;

    generational_pool_repl #(.N_BLOCKS(NB), .N_POOLS(NP)) i_generational_pool_repl (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_idx(hit_idx),
        .miss_req(miss_req), .busy(busy), .victim_valid(victim_valid),
        .victim_idx(victim_idx)
    );

    always #5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model
    int unsigned mq [NL][$];
    bit mref [NB];
    int mst;      // 0 idle, 1 proc, 2 vict
    int mstep;
    bit mmask [NL];
    bit exp_busy, exp_vv;
    int exp_vi;
    string last_tag = "R1";

    function automatic int next_pool(int p, bit r);
        if (p == FR) return r ? 1 : 0;
        if (r) return (p == NP - 1) ? p : p + 1;
        return (p == 0) ? 0 : p - 1;
    endfunction

    function automatic void model_reset();
        for (int l = 0; l < NL; l++) mq[l].delete();
        for (int i = 0; i < NB; i++) begin
            mq[0].push_back(i);
            mref[i] = 0;
        end
        mst = 0; mstep = 0;
        exp_busy = 0; exp_vv = 0; exp_vi = 0;
    endfunction

    function automatic void model_edge(bit m, bit hv, int hi);
        exp_vv = 0;
        if (mst == 0) begin
            if (m) begin
                mst = 1; mstep = 0;
                for (int l = 0; l < NL; l++) mmask[l] = (mq[l].size() != 0);
            end
        end else if (mst == 1) begin
            int p;
            p = (mstep == 0) ? FR : mstep - 1;
            if (mmask[p]) begin
                int unsigned h;
                bit r;
                int d;
                h = mq[p][0];
                r = mref[h];
                mref[h] = 0;
                d = next_pool(p, r);
                if (!(p == 0 && !r)) begin
                    void'(mq[p].pop_front());
                    mq[d].push_back(h);
                end
            end
            if (mstep == NP) mst = 2;
            mstep++;
        end else begin
            int v;
            int unsigned h;
            v = FR;
            for (int p = NP - 1; p >= 0; p--) if (mq[p].size() != 0) v = p;
            h = mq[v].pop_front();
            mq[FR].push_back(h);
            mref[h] = 0;
            exp_vv = 1; exp_vi = int'(h);
            mst = 0;
        end
        if (hv) mref[hi] = 1;
        exp_busy = (mst != 0);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(bit m, bit hv, int hi, string tag);
        @(negedge clk);
        check(last_tag, "busy", int'(busy), int'(exp_busy));
        check(last_tag, "victim_valid", int'(victim_valid), int'(exp_vv));
        if (exp_vv) check(last_tag, "victim_idx", int'(victim_idx), exp_vi);
        miss_req = m; hit_valid = hv; hit_idx = IW'(hi);
        last_tag = tag;
        model_edge(m, hv, hi);
    endtask

    task automatic do_miss(string tag, bit hold_miss, bit hits_busy);
        cyc(1, 0, 0, tag);
        while (mst != 0) begin
            bit hv;
            int hi;
            hv = hits_busy && ($urandom % 2 == 0);
            hi = hits_busy ? (mq[FR].size() != 0 && $urandom % 2 == 0 ? int'(mq[FR][0]) : int'($urandom % NB)) : 0;
            cyc(hold_miss, hv, hi, tag);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "victim_valid after reset", int'(victim_valid), 0);
        rst = 1'b0;
        cyc(0, 0, 0, "R1");
        // R1: with no hits victims rotate 0,1,2,...
        for (int k = 0; k < 4; k++) do_miss("R1", 0, 0);
        // R3: miss_req held high while busy
        for (int k = 0; k < 3; k++) do_miss("R3", 1, 0);
        cyc(0, 0, 0, "R3");
        // R4: idle hits only touch the bit
        cyc(0, 1, 5, "R4");
        cyc(0, 1, 7, "R4");
        cyc(0, 0, 0, "R4");
        for (int k = 0; k < 4; k++) do_miss("R4", 0, 0);
        // R6: repeated hits on all slots push blocks to the top pool
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < NB; i++) cyc(0, 1, i, "R6");
            for (int k = 0; k < 3; k++) do_miss("R6", 0, 0);
        end
        // R5: leave everything unreferenced so blocks drain downward
        for (int k = 0; k < 20; k++) do_miss("R5", 0, 0);
        // R7: reference the fresh-pool head before a miss
        for (int k = 0; k < 6; k++) begin
            if (mq[FR].size() != 0) cyc(0, 1, int'(mq[FR][0]), "R7");
            do_miss("R7", 0, 0);
        end
        // R9: hits during busy, including on heads being cleared
        for (int k = 0; k < 30; k++) do_miss("R9", 0, 1);
        // R8: random mix
        for (int c = 0; c < 4000; c++) begin
            bit m, hv;
            m  = ($urandom % 4 == 0);
            hv = ($urandom % 2 == 0);
            cyc(m, hv, int'($urandom % NB), "R8");
        end
        for (int c = 0; c < NP + 4; c++) cyc(0, 0, 0, "R8");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule